// File: doc/BRIEF.md
# Scan Test Port Controller with Self-Test Instruction

This block is the serial test port of a chip. A scan clock and a mode-select line walk a sixteen-state controller; a four-bit instruction chooses which data register sits between the serial input and the serial output. The registers are a one-bit bypass, a fixed 32-bit device identity word, and a one-bit self-test result. The boundary cells live outside this block. It only sends them a select, a drive-mode level and capture, shift and update strobes, and it takes back their serial output.

The self-test instruction is meant for a long run of idle scan clocks. While it is the active instruction and the controller rests in Run-Test/Idle, the block counts rising clock edges. After `RUN_CYCLES` of them it latches a pass/fail bit taken from the core's done and fail lines. The default count is 1,200,000 edges, and a bench can set a small value. The port is a bit-serial protocol paced only by the scan clock. It has no valid/ready handshake and no back-pressure, so every pin is a plain level or strobe.

Top module: `jtag_tap_bist`

## Requirements
- R1: The controller follows the standard sixteen-state scan controller graph on rising `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. `trst_n` low forces that state at once.
- R2: In Test-Logic-Reset the active instruction becomes IDCODE (0010). A data scan made right after reset, with no instruction scan, returns the identity word.
- R3: Capture-IR loads the instruction shifter with 0001, and that value is shifted out first, LSB first. The active instruction changes only at Update-IR.
- R4: Opcodes: EXTEST 0000, SAMPLE 0001, IDCODE 0010, RUNBIST 1000, BYPASS 1111. Every other code acts as BYPASS.
- R5: The bypass register captures 0 and then adds exactly one bit of delay between `tdi` and `tdo`.
- R6: The identity word is 0x10281013, shifted out LSB first. From the MSB down its fields are version 0001, supply bit 0, part number 000001010000001, maker code 00000001001 and a fixed 1 in bit 0.
- R7: EXTEST and SAMPLE both raise `bsr_select`, take `tdo` from `bsr_so`, and pulse `bsr_capture`, `bsr_shift` and `bsr_update` in the matching data states. Only EXTEST raises `bsr_mode`.
- R8: While RUNBIST is active and the controller is in Run-Test/Idle, each rising edge counts and `bist_run` is high. After `RUN_CYCLES` counted edges the count stops and `bist_run` falls. Selecting another instruction clears the count.
- R9: The self-test register reads 1 until the count completes. At completion it latches 0 only if `bist_done` is 1 and `bist_fail` is 0, and 1 otherwise. Test-Logic-Reset sets it back to 1.
- R10: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| bsr_select | output | 1 | Boundary chain is the selected data register |
| bsr_mode | output | 1 | Boundary cells drive the pins (EXTEST) |
| bsr_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bsr_update | output | 1 | Boundary update strobe (Update-DR) |
| bist_run | output | 1 | Core self-test enable while counting |
| bist_done | input | 1 | Core self-test finished |
| bist_fail | input | 1 | Core self-test found an error |

## Verification
A controller state that has drifted shows up at `tdo_oe` on the next falling edge. It also shows in the first bit of the following scan, because each scan leads with the captured pattern: 0001 for the instruction, 0 for bypass, or the identity LSB. A wrong active instruction shows in the length and content of the next data scan. A miscounting self-test counter shows as `bist_run` falling at the wrong edge, or as a result bit that reads pass one scan too early or too late around the exact completion edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUND, DR_SELFTEST} dr_sel_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_RUNBIST = 4'b1000;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        ST_RESET:  ir_q  <= OP_IDCODE;
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end

  assign ir_so = ir_sh[0];
endmodule

// File: rtl/tap_selftest.sv
module tap_selftest #(
  parameter int RUN_CYCLES = 1200000,
  localparam int CNT_W = $clog2(RUN_CYCLES + 1)
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             armed,
  input  logic             in_idle,
  input  logic             in_reset,
  input  logic             core_done,
  input  logic             core_fail,
  output logic             result,
  output logic             running,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_CYCLES);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(RUN_CYCLES - 1);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cnt    <= '0;
      result <= 1'b1;
    end else if (in_reset) begin
      cnt    <= '0;
      result <= 1'b1;
    end else if (!armed) begin
      cnt    <= '0;
    end else if (in_idle && cnt != LAST) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == PRE) result <= !(core_done && !core_fail);
    end
  end

  assign running = armed && in_idle && (cnt != LAST);
endmodule

// File: rtl/jtag_tap_bist.sv
module jtag_tap_bist
  import jtag_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'b0001,
  parameter logic        ID_SUPPLY  = 1'b0,
  parameter logic [14:0] ID_PART    = 15'b000001010000001,
  parameter logic [10:0] ID_MAKER   = 11'b00000001001,
  parameter int          RUN_CYCLES = 1200000,
  localparam int         ID_W       = 32,
  localparam int         CNT_W      = $clog2(RUN_CYCLES + 1)
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  input  logic bsr_so,
  output logic bsr_select,
  output logic bsr_mode,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bist_run,
  input  logic bist_done,
  input  logic bist_fail
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_SUPPLY, ID_PART, ID_MAKER, 1'b1};

  tap_state_e       state;
  logic [IR_W-1:0]  ir_q;
  logic             ir_so;
  logic             st_result;
  logic [CNT_W-1:0] st_cnt;
  dr_sel_e          dr_sel;
  logic [ID_W-1:0]  id_sh;
  logic             byp_q, st_sh, dr_so;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
               .ir_q(ir_q), .ir_so(ir_so));

  tap_selftest #(.RUN_CYCLES(RUN_CYCLES)) u_st (
    .tck(tck), .trst_n(trst_n),
    .armed(ir_q == OP_RUNBIST), .in_idle(state == ST_IDLE), .in_reset(state == ST_RESET),
    .core_done(bist_done), .core_fail(bist_fail),
    .result(st_result), .running(bist_run), .cnt(st_cnt));

  // instruction decode; unlisted codes fall to bypass
  always_comb begin
    case (ir_q)
      OP_EXTEST, OP_SAMPLE: dr_sel = DR_BOUND;
      OP_IDCODE:            dr_sel = DR_IDENT;
      OP_RUNBIST:           dr_sel = DR_SELFTEST;
      default:              dr_sel = DR_BYPASS;
    endcase
  end

  // data registers held in this block
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sh <= ID_WORD;
      byp_q <= 1'b0;
      st_sh <= 1'b1;
    end else if (state == ST_CAP_DR) begin
      id_sh <= ID_WORD;
      byp_q <= 1'b0;
      st_sh <= st_result;
    end else if (state == ST_SH_DR) begin
      id_sh <= {tdi, id_sh[ID_W-1:1]};
      byp_q <= tdi;
      st_sh <= tdi;
    end
  end

  always_comb begin
    case (dr_sel)
      DR_IDENT:    dr_so = id_sh[0];
      DR_BOUND:    dr_so = bsr_so;
      DR_SELFTEST: dr_so = st_sh;
      default:     dr_so = byp_q;
    endcase
  end

  // boundary chain controls
  assign bsr_select  = (dr_sel == DR_BOUND);
  assign bsr_mode    = (ir_q == OP_EXTEST);
  assign bsr_capture = bsr_select && (state == ST_CAP_DR);
  assign bsr_shift   = bsr_select && (state == ST_SH_DR);
  assign bsr_update  = bsr_select && (state == ST_UPD_DR);

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end
endmodule

// File: rtl/jtag_tap_bist_chk.sv
module jtag_tap_bist_chk
  import jtag_tap_pkg::*;
#(
  parameter int RUN_CYCLES = 1200000,
  localparam int CNT_W = $clog2(RUN_CYCLES + 1)
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tms,
  input tap_state_e       state,
  input logic [IR_W-1:0]  ir,
  input logic [CNT_W-1:0] cnt,
  input logic             tdo_oe,
  input logic             bsr_select,
  input logic             bsr_mode,
  input logic             bsr_capture,
  input logic             bist_run
);
  a_r1_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_RESET);

  a_r2_reset_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_RESET |=> ir == OP_IDCODE);

  a_r3_ir_held_outside_update: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir));

  a_r7_mode_implies_select: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_mode || bsr_capture) |-> bsr_select);

  a_r8_count_bounded: assert property (@(posedge tck) disable iff (!trst_n)
    cnt <= CNT_W'(RUN_CYCLES));

  a_r8_run_only_idle: assert property (@(posedge tck) disable iff (!trst_n)
    bist_run |-> (state == ST_IDLE && ir == OP_RUNBIST));

  a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

bind jtag_tap_bist jtag_tap_bist_chk #(.RUN_CYCLES(RUN_CYCLES)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir(ir_q), .cnt(st_cnt),
  .tdo_oe(tdo_oe), .bsr_select(bsr_select), .bsr_mode(bsr_mode),
  .bsr_capture(bsr_capture), .bist_run(bist_run));

// File: tb/test_jtag_tap_bist.sv
module test_jtag_tap_bist;
  localparam int RUN = 40;

  logic tck = 1'b0;
  logic trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic bist_done = 1'b0, bist_fail = 1'b0;
  logic tdo, tdo_oe, bsr_select, bsr_mode, bsr_capture, bsr_shift, bsr_update, bist_run;

  int checks = 0, errors = 0;
  logic tdo_last, oe_last, shift_seen, finished = 1'b0;

  always #5 tck = ~tck;

  jtag_tap_bist #(.RUN_CYCLES(RUN)) i_jtag_tap_bist (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_so(bsr_so), .bsr_select(bsr_select), .bsr_mode(bsr_mode),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bist_run(bist_run), .bist_done(bist_done), .bist_fail(bist_fail));

  function automatic logic [31:0] id_word();
    return {4'b0001, 1'b0, 15'b000001010000001, 11'b00000001001, 1'b1};
  endfunction

  function automatic logic [63:0] exp_dr(logic [3:0] op, logic [63:0] din, logic bso);
    logic [63:0] r;
    case (op)
      4'b0010: r = {din[31:0], id_word()};
      4'b0000, 4'b0001: r = {64{bso}};
      default: r = {din[62:0], 1'b0};
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
    tdo_last = tdo; oe_last = tdo_oe;
  endtask

  task automatic scan_ir(logic [3:0] op, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin cap[i] = tdo_last; step(i == 3, op[i]); end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(int n, logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    shift_seen = bsr_shift;
    for (int i = 0; i < n; i++) begin dout[i] = tdo_last; step(i == n - 1, din[i]); end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap;
    logic [63:0] dout, din;
    void'($urandom(32'd1234));
    #23 trst_n = 1'b1;
    @(negedge tck); #1;
    check("R10 oe low after reset", {63'd0, tdo_oe}, 64'd0);
    step(0, 0);
    // R2: identity selected straight after reset; R6 word value
    scan_dr(32, 64'd0, dout);
    check("R2 R6 identity after reset", dout, {32'd0, 32'h10281013});
    check("R6 fields", {32'd0, id_word()}, {32'd0, 32'h10281013});
    // R3 capture pattern, R5 bypass, R10 oe
    scan_ir(4'b1111, cap);
    check("R3 IR capture 0001", {60'd0, cap}, 64'd1);
    scan_dr(8, 64'hA5, dout);
    check("R5 bypass delay", dout, {56'd0, 8'h4A});
    check("R10 oe low in idle", {63'd0, oe_last}, 64'd0);
    // R7 EXTEST versus SAMPLE
    bsr_so = 1'b1;
    scan_ir(4'b0000, cap);
    check("R7 extest mode", {62'd0, bsr_mode, bsr_select}, 64'd3);
    scan_dr(6, 64'h0, dout);
    check("R7 extest serial from chain", dout, 64'h3F);
    check("R7 shift strobe", {63'd0, shift_seen}, 64'd1);
    scan_ir(4'b0001, cap);
    check("R7 sample no mode", {62'd0, bsr_mode, bsr_select}, 64'd1);
    bsr_so = 1'b0;
    // R4 private opcode behaves as bypass
    scan_ir(4'b0110, cap);
    scan_dr(5, 64'h1B, dout);
    check("R4 private is bypass", dout, 64'h16);
    // R8 R9 self-test: pass case, exact completion edge
    bist_done = 1'b1; bist_fail = 1'b0;
    scan_ir(4'b1000, cap);
    for (int i = 0; i < RUN - 2; i++) step(0, 0);
    check("R8 run high while counting", {63'd0, bist_run}, 64'd1);
    scan_dr(1, 64'd0, dout); // leaving edge makes count RUN-1
    check("R9 not yet complete reads 1", dout, 64'd1);
    scan_dr(1, 64'd0, dout); // leaving edge completes the count
    check("R9 pass reads 0", dout, 64'd0);
    check("R8 run low after completion", {63'd0, bist_run}, 64'd0);
    // R8 R9 fail case after reselect clears the count
    bist_fail = 1'b1;
    scan_ir(4'b1111, cap);
    scan_ir(4'b1000, cap);
    for (int i = 0; i < RUN; i++) step(0, 0);
    scan_dr(1, 64'd0, dout);
    check("R9 fail reads 1", dout, 64'd1);
    // R1 five tms-high cycles reset, R2 IDCODE restored
    scan_ir(4'b1111, cap);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    scan_dr(32, 64'd0, dout);
    check("R1 R2 tms reset to identity", dout, {32'd0, id_word()});
    // R1 asynchronous reset in mid shift
    scan_ir(4'b1111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    #2 trst_n = 1'b0; #1;
    check("R1 R10 async reset oe", {63'd0, tdo_oe}, 64'd0);
    #4 trst_n = 1'b1;
    step(0, 0);
    scan_dr(32, 64'd0, dout);
    check("R1 async reset identity", dout, {32'd0, id_word()});
    // random opcodes and data (R4 R5 R6 R7)
    for (int k = 0; k < 40; k++) begin
      logic [3:0] op;
      op = 4'($urandom % 16);
      if (op == 4'b1000) op = 4'b1111;
      bsr_so = 1'($urandom);
      din = {$urandom, $urandom};
      scan_ir(op, cap);
      check("R3 capture pattern", {60'd0, cap}, 64'd1);
      scan_dr(40, din, dout);
      check("R4 random opcode data", dout, exp_dr(op, din, bsr_so) & 64'hFF_FFFF_FFFF);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule